// File: doc/BRIEF.md
# Masked Monitoring Fault Detector

This block watches a set of already-digitized inputs while a power sequencer sits in a monitoring state, for example after all rails are up. The inputs can be supply comparator results as well as plain logic-level signals. Each input has an expected level and an ignore bit. An input that is not ignored and sits at the wrong level is a deviation. All deviations are merged by a wide OR into one trip signal, which the sequencer's transition logic consumes.

Supply faults must be answered as fast as possible, so there is no delay or deglitch filter. The per-input deviation vector is combinational and valid in the same cycle. The combined trip flag and a registered copy of the per-input vector update on the very next clock edge. A monitor-enable input forces both registered outputs low whenever the sequencer is outside a monitoring state. A synchronous active-low reset clears them.

Top module: `mfd_monitor`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `trip` and every bit of `trip_vec` are 0 after that edge, whatever the other inputs are.
- R2: `dev_now[i]` is 1 exactly when `ignore[i]` is 0 and `obs[i]` differs from `expect_hi[i]`. It is combinational, valid in the same cycle, and not gated by `mon_en`.
- R3: An input with `ignore[i]` = 1 never sets `dev_now[i]` or `trip_vec[i]` and never causes `trip`, whatever its level.
- R4: `expect_hi[i]` = 1 means the input should be high, so a low level deviates. `expect_hi[i]` = 0 means it should be low, so a high level deviates.
- R5: If `mon_en` is 1 and at least one bit of `dev_now` is 1 at a rising edge, `trip` is 1 after that edge. A deviation lasting a single cycle is enough.
- R6: After each rising edge out of reset, `trip_vec` equals the `dev_now` vector at that edge when `mon_en` was 1, and is all zeros otherwise.
- R7: If `mon_en` is 0 at a rising edge, `trip` and `trip_vec` are 0 after it, even when deviations are present.
- R8: `trip` is not sticky. It returns to 0 on the first rising edge at which no bit of `dev_now` is 1.
- R9: A deviation on any single bit position 0 through N-1 is enough to raise `trip`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mon_en | input | 1 | 1 while the sequencer is in a monitoring state |
| obs | input | N | Digitized comparator and logic inputs |
| expect_hi | input | N | Expected level of each input (1 = high) |
| ignore | input | N | Per-input mask (1 = never a fault) |
| dev_now | output | N | Combinational per-input deviation flags |
| trip_vec | output | N | Registered per-input flags, gated by mon_en |
| trip | output | 1 | Registered combined fault flag |

## Verification
`dev_now` has no register in its path. The bench therefore checks it 1 ns after driving the inputs at a falling edge, within the same cycle. `trip` and `trip_vec` each pass through one register. For every vector the bench checks them at the next falling edge, which is half a period after the single rising edge that captures them. Inputs change only at falling edges, so each registered check sees exactly one capture of the vector before it. Glitch, clear and reset cases follow the same rule with one edge per step, which shows that nothing needs more than one edge.

// File: rtl/mfd_pkg.sv
package mfd_pkg;

    localparam int unsigned MFD_DEFAULT_N = 10;

    // One input's fault rule: not masked and away from its expected level.
    function automatic logic mfd_deviates(input logic obs_b,
                                          input logic exp_b,
                                          input logic ign_b);
        return (!ign_b) && (obs_b != exp_b);
    endfunction

endpackage

// File: rtl/mfd_bit_det.sv
module mfd_bit_det
    import mfd_pkg::*;
(
    input  logic obs_b,
    input  logic exp_b,
    input  logic ign_b,
    output logic dev_b
);

    always_comb begin
        dev_b = mfd_deviates(obs_b, exp_b, ign_b);
    end

endmodule

// File: rtl/mfd_wide_or.sv
module mfd_wide_or #(
    parameter int unsigned W = 10
) (
    input  logic [W-1:0] bits,
    output logic         any
);

    localparam int unsigned LAST = W - 1;

    logic [W-1:0] chain;

    assign chain[0] = bits[0];

    genvar g;
    generate
        for (g = 1; g < W; g++) begin : g_chain
            assign chain[g] = chain[g-1] | bits[g];
        end
    endgenerate

    assign any = chain[LAST];

endmodule

// File: rtl/mfd_monitor.sv
module mfd_monitor
    import mfd_pkg::*;
#(
    parameter int unsigned N = MFD_DEFAULT_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mon_en,
    input  logic [N-1:0] obs,
    input  logic [N-1:0] expect_hi,
    input  logic [N-1:0] ignore,
    output logic [N-1:0] dev_now,
    output logic [N-1:0] trip_vec,
    output logic         trip
);

    typedef struct packed {
        logic         trip;
        logic [N-1:0] vec;
    } mon_state_t;

    localparam mon_state_t MON_RESET = '{trip: 1'b0, vec: '0};

    mon_state_t st_d, st_q;
    logic       any_dev;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            mfd_bit_det u_det (
                .obs_b (obs[i]),
                .exp_b (expect_hi[i]),
                .ign_b (ignore[i]),
                .dev_b (dev_now[i])
            );
        end
    endgenerate

    mfd_wide_or #(.W(N)) u_or (
        .bits (dev_now),
        .any  (any_dev)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d = MON_RESET;
        end else if (!mon_en) begin
            st_d = MON_RESET;
        end else begin
            st_d.trip = any_dev;
            st_d.vec  = dev_now;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign trip     = st_q.trip;
    assign trip_vec = st_q.vec;

    // R1: the first edge after a reset cycle leaves everything clear
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!trip && (trip_vec == '0)));

    // R3: an ignored input never shows a deviation
    a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_now & ignore) == '0));

    // R5: an enabled deviation trips on the next edge
    a_r5_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && (dev_now != '0)) |=> trip);

    // R7: monitoring off forces the outputs low
    a_r7_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> (!trip && (trip_vec == '0)));

    // R8: no deviation, no trip on the next edge
    a_r8_not_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_now == '0) |=> !trip);

    // R6: the registered vector agrees with the combined flag
    a_r6_vec_matches_trip: assert property (@(posedge clk) disable iff (!rst_n)
        trip == (trip_vec != '0));

endmodule

// File: tb/test_mfd_monitor.sv
`timescale 1ns/1ps
module test_mfd_monitor;

    localparam int N = 10;
    localparam int SPACE = 1 << N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mon_en = 1'b0;
    logic [N-1:0] obs = '0;
    logic [N-1:0] expect_hi = '0;
    logic [N-1:0] ignore = '0;
    logic [N-1:0] dev_now;
    logic [N-1:0] trip_vec;
    logic         trip;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mfd_monitor #(.N(N)) i_mfd_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_en    (mon_en),
        .obs       (obs),
        .expect_hi (expect_hi),
        .ignore    (ignore),
        .dev_now   (dev_now),
        .trip_vec  (trip_vec),
        .trip      (trip)
    );

    task automatic chk(input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp_v);
        n_vec++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp_v);
        end
    endtask

    function automatic logic [N-1:0] model_dev(input logic [N-1:0] o,
                                               input logic [N-1:0] e,
                                               input logic [N-1:0] m);
        return (o ^ e) & ~m;
    endfunction

    // Drive at a falling edge, check dev_now in the same cycle, then check the
    // registered outputs at the next falling edge.
    task automatic apply(input string req, input logic en,
                         input logic [N-1:0] o, input logic [N-1:0] e,
                         input logic [N-1:0] m);
        logic [N-1:0] d;
        mon_en = en; obs = o; expect_hi = e; ignore = m;
        d = model_dev(o, e, m);
        #1;
        chk({req, " R2 dev_now"}, dev_now, d);
        @(negedge clk);
        chk({req, " R6 trip_vec"}, trip_vec, en ? d : '0);
        chk({req, " R5 trip"}, {{(N-1){1'b0}}, trip}, {{(N-1){1'b0}}, (en && d != '0)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] cfg_m, cfg_e;
        // R1: reset state, with deviations and monitoring active
        mon_en = 1'b1; obs = '1; expect_hi = '0; ignore = '0;
        repeat (2) @(negedge clk);
        chk("R1 reset trip", {{(N-1){1'b0}}, trip}, '0);
        chk("R1 reset trip_vec", trip_vec, '0);
        rst_n = 1'b1;

        // R9: each single position alone trips
        for (int b = 0; b < N; b++)
            apply("R9 single bit", 1'b1, N'(1) << b, '0, '0);

        // R4: expecting high, a low level deviates; expecting low, a high one does
        apply("R4 expect hi seen lo", 1'b1, '0, '1, '0);
        apply("R4 expect hi seen hi", 1'b1, '1, '1, '0);
        apply("R4 expect lo seen lo", 1'b1, '0, '0, '0);

        // R3: all masked while everything deviates
        apply("R3 all ignored", 1'b1, '1, '0, '1);
        chk("R3 trip quiet", {{(N-1){1'b0}}, trip}, '0);

        // R7: deviations with monitoring off
        apply("R7 disabled", 1'b0, '1, '0, '0);

        // R5/R8: a one-cycle glitch is caught and then clears
        apply("R5 glitch", 1'b1, N'(1) << 3, '0, '0);
        apply("R8 clear", 1'b1, '0, '0, '0);
        chk("R8 trip clear", {{(N-1){1'b0}}, trip}, '0);

        // Sweep: every obs pattern under several computed mask/sense configs
        for (int c = 0; c < 8; c++) begin
            cfg_m = (c == 0) ? '0 : N'((c * 193 + 5) % SPACE);
            cfg_e = N'((c * 411 + 77) % SPACE);
            for (int v = 0; v < SPACE; v++)
                apply("R2/R6 sweep", (v % 7) != 0, N'(v), cfg_e, cfg_m);
        end

        // R1: reset while tripped
        apply("R1 pre-reset", 1'b1, '1, '0, '0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-run trip", {{(N-1){1'b0}}, trip}, '0);
        chk("R1 reset mid-run vec", trip_vec, '0);
        rst_n = 1'b1;
        apply("R5 after reset", 1'b1, '1, '0, '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule